// File: doc/BRIEF.md
# Way-Configurable Byte Cache Lookup

This block is the tag and data array of a small byte-addressed cache with eight lines of eight bytes. One parameter picks how many ways the eight lines are split into: 1 gives a direct-mapped array, 2 or 4 give a set-associative array, and 8 gives a fully associative array with no index field. The CPU side presents a byte address and gets back, in the same cycle, whether the byte is present, which way holds it, and the byte itself. A write strobe stores one byte into the line that hit, at the next clock edge.

Lines are brought in through a separate fill port. The fill port writes a whole line, its tag and its valid bit into a way chosen by the caller, in a single cycle. The choice of victim, traffic to main memory and the sequencing of a miss all live outside this block.

Top module: `assoc_lookup_cache`

## Requirements
- R1: The array holds `NUM_LINES` = 8 lines of `LINE_BYTES` = 8 bytes, split into `WAYS` ways of `NUM_LINES/WAYS` sets each. With every line filled under distinct addresses, exactly 64 byte addresses hit.
- R2: The byte address is split into fields. Bits [2:0] are the byte offset. The next log2(8/WAYS) bits are the set index, which is bits [4:3] at 2 ways and is absent at 8 ways. All bits above the index are the tag.
- R3: `hit` is high in the same cycle as the address only when some way of the indexed set holds a valid line whose stored tag equals the address tag. Every way of the set is compared at once.
- R4: `hit_way` has bit w set for the way that hit. It is all zero on a miss and it is never multi-hot. While `cpu_req` is low, `hit` and `hit_way` are zero.
- R5: On a hit, `rdata` is the byte at the address offset within the hitting line. On a miss it is 0.
- R6: A write (`cpu_req` and `cpu_we` high) that hits stores `cpu_wdata` into the addressed byte at the clock edge and leaves the other bytes unchanged. A write that misses changes nothing.
- R7: A fill stores the tag and the index of `fill_laddr`, sets the valid bit, and writes all eight bytes into way `fill_way` at one clock edge. Byte k comes from `fill_line[8k+7:8k]`. The line hits from the next cycle.
- R8: A fill or a write changes only the line it targets. Other ways of the same set and other sets keep their contents.
- R9: Reset clears every valid bit, so every address misses afterwards.
- R10: When a fill and a hitting write target the same way and set at the same edge, the fill data wins and the write is dropped.
- R11: A fill into an occupied way replaces the old line. The old address then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears valid bits |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | Write strobe, qualified by cpu_req |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| hit | output | 1 | Lookup hit |
| hit_way | output | WAYS | One-hot way that hit |
| rdata | output | 8 | Byte read on hit, else 0 |
| fill_en | input | 1 | Line fill strobe |
| fill_way | input | WAY_W | Target way of the fill |
| fill_laddr | input | ADDR_W-3 | Line address (tag and index) of the fill |
| fill_line | input | 64 | Eight line bytes, byte k at bits 8k+7:8k |

## Verification
The hardest case to reach from the ports is a fill and a hitting byte write landing on the same way and set at the same edge, where only one of the two may take effect. The bench first fills every line, so the write is sure to hit. It then drives the write and a replacing fill of that very line in one cycle. After that it repeats the pairing with the fill aimed at the other way of the set, where both must take effect. Full 4096-address sweeps after each phase then show that no other line was disturbed and that both ways of each set resolve independently.

// File: rtl/cache_geom_pkg.sv
package cache_geom_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cache_addr_split.sv
// Splits a line address (byte address without its offset) into set index and tag.
module cache_addr_split #(
    parameter int LADDR_W = 9,
    parameter int IDX_W   = 2,
    parameter int IDX_WS  = 2,
    parameter int TAG_W   = 7
) (
    input  logic [LADDR_W-1:0] laddr,
    output logic [IDX_WS-1:0]  idx,
    output logic [TAG_W-1:0]   tag
);
    generate
        if (IDX_W == 0) begin : g_no_index
            assign idx = '0;
            assign tag = laddr;
        end else begin : g_index
            assign idx = laddr[IDX_W-1:0];
            assign tag = laddr[LADDR_W-1:IDX_W];
        end
    endgenerate
endmodule

// File: rtl/cache_way.sv
// One way: per-set tag, valid bit and line bytes, plus its own tag comparator.
module cache_way
    import cache_geom_pkg::*;
#(
    parameter int SETS       = 4,
    parameter int IDX_WS     = 2,
    parameter int TAG_W      = 7,
    parameter int LINE_BYTES = 8,
    parameter int OFF_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_WS-1:0]            lk_idx,
    input  logic [TAG_W-1:0]             lk_tag,
    input  logic [OFF_W-1:0]             lk_off,
    input  logic                         wr_en,
    input  byte_t                        wr_data,
    input  logic                         fl_en,
    input  logic [IDX_WS-1:0]            fl_idx,
    input  logic [TAG_W-1:0]             fl_tag,
    input  logic [LINE_BYTES-1:0][BYTE_W-1:0] fl_line,
    output logic                         match,
    output byte_t                        rbyte
);
    logic [SETS-1:0]                    valid_q;
    logic [TAG_W-1:0]                   tag_q  [SETS];
    logic [LINE_BYTES-1:0][BYTE_W-1:0]  line_q [SETS];
    logic                               collide;

    assign collide = fl_en && (fl_idx == lk_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fl_en) begin
            valid_q[fl_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fl_en) begin
            tag_q[fl_idx]  <= fl_tag;
            line_q[fl_idx] <= fl_line;
        end
        if (wr_en && !collide) begin
            line_q[lk_idx][lk_off] <= wr_data;
        end
    end

    assign match = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign rbyte = line_q[lk_idx][lk_off];
endmodule

// File: rtl/cache_hit_select.sv
// Gates per-way matches with the request and merges the way bytes.
module cache_hit_select
    import cache_geom_pkg::*;
#(
    parameter int WAYS = 2
) (
    input  logic                          req,
    input  logic [WAYS-1:0]               match,
    input  logic [WAYS-1:0][BYTE_W-1:0]   rbytes,
    output logic                          hit,
    output logic [WAYS-1:0]               hit_way,
    output byte_t                         rdata
);
    always_comb begin
        rdata = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (req && match[w]) begin
                rdata = rdata | rbytes[w];
            end
        end
    end

    assign hit_way = req ? match : '0;
    assign hit     = |hit_way;
endmodule

// File: rtl/assoc_lookup_cache.sv
module assoc_lookup_cache
    import cache_geom_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_LINES  = 8,
    parameter int LINE_BYTES = 8,
    parameter int WAYS       = 2,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_W    = LINE_BYTES * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [BYTE_W-1:0]     cpu_wdata,
    output logic                  hit,
    output logic [WAYS-1:0]       hit_way,
    output logic [BYTE_W-1:0]     rdata,
    input  logic                  fill_en,
    input  logic [WAY_W-1:0]      fill_way,
    input  logic [ADDR_W-OFF_W-1:0] fill_laddr,
    input  logic [LINE_W-1:0]     fill_line
);
    localparam int SETS    = NUM_LINES / WAYS;
    localparam int IDX_W   = $clog2(SETS);
    localparam int IDX_WS  = (IDX_W > 0) ? IDX_W : 1;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int TAG_W   = LADDR_W - IDX_W;

    logic [IDX_WS-1:0]             cpu_idx, fil_idx;
    logic [TAG_W-1:0]              cpu_tag, fil_tag;
    logic [OFF_W-1:0]              cpu_off;
    logic [WAYS-1:0]               way_match;
    logic [WAYS-1:0][BYTE_W-1:0]   way_rbyte;

    assign cpu_off = cpu_addr[OFF_W-1:0];

    cache_addr_split #(
        .LADDR_W(LADDR_W), .IDX_W(IDX_W), .IDX_WS(IDX_WS), .TAG_W(TAG_W)
    ) u_cpu_split (
        .laddr(cpu_addr[ADDR_W-1:OFF_W]), .idx(cpu_idx), .tag(cpu_tag)
    );

    cache_addr_split #(
        .LADDR_W(LADDR_W), .IDX_W(IDX_W), .IDX_WS(IDX_WS), .TAG_W(TAG_W)
    ) u_fill_split (
        .laddr(fill_laddr), .idx(fil_idx), .tag(fil_tag)
    );

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic fill_sel;
            logic wr_sel;
            assign fill_sel = fill_en && (fill_way == WAY_W'(w));
            assign wr_sel   = cpu_req && cpu_we && way_match[w];

            cache_way #(
                .SETS(SETS), .IDX_WS(IDX_WS), .TAG_W(TAG_W),
                .LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)
            ) u_way (
                .clk     (clk),
                .rst_n   (rst_n),
                .lk_idx  (cpu_idx),
                .lk_tag  (cpu_tag),
                .lk_off  (cpu_off),
                .wr_en   (wr_sel),
                .wr_data (cpu_wdata),
                .fl_en   (fill_sel),
                .fl_idx  (fil_idx),
                .fl_tag  (fil_tag),
                .fl_line (fill_line),
                .match   (way_match[w]),
                .rbyte   (way_rbyte[w])
            );
        end
    endgenerate

    cache_hit_select #(.WAYS(WAYS)) u_sel (
        .req     (cpu_req),
        .match   (way_match),
        .rbytes  (way_rbyte),
        .hit     (hit),
        .hit_way (hit_way),
        .rdata   (rdata)
    );
endmodule

// File: rtl/cache_lookup_checker.sv
module cache_lookup_checker #(
    parameter int ADDR_W = 12,
    parameter int WAYS   = 2,
    parameter int OFF_W  = 3,
    parameter int WAY_W  = 1,
    parameter int LINE_W = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cpu_req,
    input logic                    cpu_we,
    input logic [ADDR_W-1:0]       cpu_addr,
    input logic [7:0]              cpu_wdata,
    input logic                    hit,
    input logic [WAYS-1:0]         hit_way,
    input logic [7:0]              rdata,
    input logic                    fill_en,
    input logic [WAY_W-1:0]        fill_way,
    input logic [ADDR_W-OFF_W-1:0] fill_laddr,
    input logic [LINE_W-1:0]       fill_line
);
    // R4: never more than one way reports a hit
    assert_single_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_way));

    // R4: an idle port reports no hit
    assert_idle_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> (hit_way == '0) && !hit);

    // R5: a miss returns zero
    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> rdata == 8'h00);

    // R6: a hitting write is read back on the next cycle
    assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_req && cpu_we && hit) && !$past(fill_en) && cpu_req
         && cpu_addr == $past(cpu_addr)) |-> hit && rdata == $past(cpu_wdata));

    // R7: a filled line hits in its way with the filled byte next cycle
    assert_fill_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_en) && cpu_req && cpu_addr[ADDR_W-1:OFF_W] == $past(fill_laddr))
        |-> hit && hit_way == (WAYS'(1) << $past(fill_way))
            && rdata == 8'($past(fill_line) >> {cpu_addr[OFF_W-1:0], 3'b000}));
endmodule

bind assoc_lookup_cache cache_lookup_checker #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .OFF_W(OFF_W), .WAY_W(WAY_W), .LINE_W(LINE_W)
) u_lookup_chk (.*);

// File: tb/test_assoc_lookup_cache.sv
module test_assoc_lookup_cache;
    localparam int ADDR_W = 12;
    localparam int WAYS   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        hit;
    logic [1:0]  hit_way;
    logic [7:0]  rdata;
    logic        fill_en = 1'b0;
    logic [0:0]  fill_way = '0;
    logic [8:0]  fill_laddr = '0;
    logic [63:0] fill_line = '0;

    int checks = 0;
    int errors = 0;

    logic [6:0]  m_tag  [2][4];
    logic        m_val  [2][4];
    logic [63:0] m_line [2][4];

    assoc_lookup_cache #(.ADDR_W(ADDR_W), .WAYS(WAYS)) i_assoc_lookup_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .hit(hit), .hit_way(hit_way),
        .rdata(rdata), .fill_en(fill_en), .fill_way(fill_way),
        .fill_laddr(fill_laddr), .fill_line(fill_line)
    );

    always #4 clk = ~clk;

    function automatic logic [6:0] tag_of(int s, int w);
        return 7'((s * 37 + w * 11 + 5) % 128);
    endfunction

    function automatic logic [63:0] line_of(int s, int w, int salt);
        logic [63:0] l;
        for (int k = 0; k < 8; k++) l[k*8 +: 8] = 8'((s * 29 + w * 71 + k * 13 + salt) % 256);
        return l;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // combinational lookup against the bench model; R2 field split: off [2:0], set [4:3], tag [11:5]
    task automatic look(input logic [11:0] a, input string req);
        logic [1:0] ew;
        logic [7:0] ed;
        ew = '0;
        ed = '0;
        cpu_addr = a; cpu_req = 1'b1; cpu_we = 1'b0;
        #1;
        for (int w = 0; w < 2; w++) begin
            if (m_val[w][a[4:3]] && m_tag[w][a[4:3]] == a[11:5]) begin
                ew[w] = 1'b1;
                ed = m_line[w][a[4:3]][a[2:0]*8 +: 8];
            end
        end
        chk(req, 64'(hit), 64'(|ew));
        chk(req, 64'(hit_way), 64'(ew));
        chk(req, 64'(rdata), 64'(ed));
    endtask

    task automatic sweep(input string req, output int nhit);
        nhit = 0;
        for (int a = 0; a < 4096; a++) begin
            look(12'(a), req);
            if (hit) nhit++;
        end
    endtask

    task automatic model_fill(input int w, input int s, input logic [6:0] t, input logic [63:0] l);
        m_val[w][s] = 1'b1; m_tag[w][s] = t; m_line[w][s] = l;
    endtask

    task automatic do_fill(input int w, input int s, input logic [6:0] t, input logic [63:0] l);
        @(negedge clk);
        fill_en = 1'b1; fill_way = 1'(w); fill_laddr = {t, 2'(s)}; fill_line = l;
        @(posedge clk);
        @(negedge clk);
        fill_en = 1'b0;
        model_fill(w, s, t, l);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_req = 1'b1; cpu_we = 1'b1; cpu_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_we = 1'b0;
        for (int w = 0; w < 2; w++)
            if (m_val[w][a[4:3]] && m_tag[w][a[4:3]] == a[11:5])
                m_line[w][a[4:3]][a[2:0]*8 +: 8] = d;
    endtask

    initial begin
        int nh;
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 4; s++) begin
                m_val[w][s] = 1'b0; m_tag[w][s] = '0; m_line[w][s] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: after reset nothing hits
        sweep("R9", nh);
        chk("R9 hit count", 64'(nh), 64'd0);

        // R7: fill every line; R2: the set field picks the set
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                do_fill(w, s, tag_of(s, w), line_of(s, w, 7));
                look({tag_of(s, w), 2'(s), 3'd5}, "R7");
                look({tag_of(s, w), 2'(s + 1), 3'd5}, "R2");
            end

        // R4: idle port reports nothing even on a resident address
        @(negedge clk);
        cpu_addr = {tag_of(1, 1), 2'd1, 3'd2}; cpu_req = 1'b0;
        #1;
        chk("R4 idle hit", 64'(hit), 64'd0);
        chk("R4 idle way", 64'(hit_way), 64'd0);
        chk("R5 idle data", 64'(rdata), 64'd0);

        // R1, R3, R5: full sweep, exactly 64 resident bytes
        sweep("R3", nh);
        chk("R1 hit count", 64'(nh), 64'd64);

        // R6: one hitting write per line, plus missing writes that change nothing
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                do_write({tag_of(s, w), 2'(s), 3'((s + w) % 8)}, 8'hC0 ^ 8'(s * 8 + w));
                look({tag_of(s, w), 2'(s), 3'((s + w) % 8)}, "R6");
                do_write({tag_of(s, 0) + 7'd1, 2'(s), 3'd0}, 8'h55);
            end
        sweep("R6", nh);
        chk("R6 hit count", 64'(nh), 64'd64);

        // R10: fill and hitting write on the same way and set at one edge
        @(negedge clk);
        cpu_addr = {tag_of(1, 0), 2'd1, 3'd3}; cpu_req = 1'b1; cpu_we = 1'b1; cpu_wdata = 8'hEE;
        fill_en = 1'b1; fill_way = 1'b0; fill_laddr = {7'h70, 2'd1}; fill_line = line_of(1, 0, 99);
        @(posedge clk);
        @(negedge clk);
        cpu_we = 1'b0; fill_en = 1'b0;
        model_fill(0, 1, 7'h70, line_of(1, 0, 99));
        look({7'h70, 2'd1, 3'd3}, "R10");
        look({tag_of(1, 0), 2'd1, 3'd3}, "R10");

        // R8: fill of way 0 and write hitting way 1 of the same set both commit
        @(negedge clk);
        cpu_addr = {tag_of(3, 1), 2'd3, 3'd6}; cpu_req = 1'b1; cpu_we = 1'b1; cpu_wdata = 8'h3C;
        fill_en = 1'b1; fill_way = 1'b0; fill_laddr = {7'h11, 2'd3}; fill_line = line_of(3, 0, 50);
        @(posedge clk);
        @(negedge clk);
        cpu_we = 1'b0; fill_en = 1'b0;
        model_fill(0, 3, 7'h11, line_of(3, 0, 50));
        m_line[1][3][6*8 +: 8] = 8'h3C;
        look({tag_of(3, 1), 2'd3, 3'd6}, "R8");
        look({7'h11, 2'd3, 3'd6}, "R8");

        // R11: replacing way 1 of set 2 drops the old line
        do_fill(1, 2, 7'h7F, line_of(2, 1, 3));
        look({tag_of(2, 1), 2'd2, 3'd0}, "R11");
        chk("R11 old miss", 64'(hit), 64'd0);
        look({7'h7F, 2'd2, 3'd4}, "R11");

        // R8: nothing else moved
        sweep("R8", nh);
        chk("R8 hit count", 64'(nh), 64'd64);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule